// File: doc/BRIEF.md
# Clock Source Select and Divider

This block is the clock-control logic of a small microcontroller. Four oscillators feed it: a watchdog oscillator, an internal RC oscillator, a crystal oscillator and an external clock input. Each is modelled as a one-cycle tick on a fast reference clock. A two-bit configuration code is captured while reset is held and picks the oscillator that serves as the oscillator clock. Writes at run time cannot change that code.

A control write can force the internal RC oscillator without a reset, and clearing that bit returns to the configured source. The selected tick stream goes through a divider. A divide value of zero passes every tick through. Any other value M yields one CPU clock enable per 2*M ticks. A new source or divide value is applied only at a divider terminal count, so no shortened CPU clock period is produced.

From the CPU clock enables the block derives three outputs:
- a peripheral clock enable at half the CPU rate;
- a machine-cycle strobe at half the CPU rate, on the other phase;
- an optional clock output pin that toggles once per CPU clock. It is allowed only while the crystal oscillator is free: not the active CPU source, and not claimed by the real-time clock or the watchdog.

Top module: `clk_ctrl_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs cpu_en, pclk_en, mcyc_stb and clkout become 0, the RC-force bit and the clock-output enable become 0, the divide value becomes 0, and cfg_src is captured as the source code.
- R2: Source codes are 0 = watchdog (osc_tick[0]), 1 = internal RC (osc_tick[1]), 2 = crystal (osc_tick[2]), 3 = external input (osc_tick[3]). Only ticks of the active source advance the divider.
- R3: Changes on cfg_src after reset has been released have no effect on which source is active.
- R4: Writing ctl_rc_force = 1 makes the internal RC oscillator the active source regardless of the captured code, with no reset. Writing it back to 0 restores the captured source.
- R5: With a divide value of 0, cpu_en is high in the cycle after each active tick.
- R6: With a divide value M from 1 to 255, cpu_en is high in the cycle after every 2*M-th active tick and low otherwise.
- R7: A newly written source selection or divide value takes effect only at a terminal count (an active tick that ends a divided period), after which counting restarts from zero.
- R8: Counting from reset, pclk_en is high one cycle after the odd-numbered cpu_en pulses and mcyc_stb is high one cycle after the even-numbered ones. The two are never high together.
- R9: When the clock output is enabled and allowed, clkout toggles one cycle after each cpu_en pulse, starting from 0.
- R10: clkout is driven to 0 on the next edge while the clock-output enable is 0, the active source is the crystal (code 2), rtc_on_xtal is 1 or wdt_on_xtal is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock on which all ticks and enables are sampled |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 4 | One-cycle tick per oscillator edge, indexed by source code |
| cfg_src | input | 2 | Configured source code, captured during reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_rc_force | input | 1 | Write data: force internal RC source |
| ctl_clkout_en | input | 1 | Write data: enable clock output pin |
| ctl_div | input | 8 | Write data: divide value M |
| rtc_on_xtal | input | 1 | Real-time clock is using the crystal |
| wdt_on_xtal | input | 1 | Watchdog is using the crystal |
| cpu_en | output | 1 | CPU clock enable pulse |
| pclk_en | output | 1 | Peripheral clock enable, half CPU rate |
| mcyc_stb | output | 1 | Machine-cycle strobe, every second CPU clock |
| clkout | output | 1 | Clock output, half CPU rate |

## Verification
Latencies:
- cpu_en rises in the cycle after the active tick that ends a divided period.
- pclk_en, mcyc_stb and the clkout toggle follow one cycle after that cpu_en, so two cycles after the tick.
- A control write registers on its own edge, but a new source or divide value is applied only at the next terminal tick of the old setting.

The bench drives each tick for exactly one cycle. It reads cpu_en 1 ns after the edge that captures the tick, and the derived outputs 1 ns after the following edge. Expected values come from tick counts set against 2*M and from the parity of the cpu_en pulses.

// File: rtl/clkgen_pkg.sv
// Package: shared source encoding for the clock control unit.
// Assumes four oscillator inputs indexed by a two-bit code.
package clkgen_pkg;
    localparam int SRC_W   = 2;
    localparam int NUM_SRC = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_WDOG = 2'd0,
        SRC_RC   = 2'd1,
        SRC_XTAL = 2'd2,
        SRC_EXT  = 2'd3
    } osc_src_e;
endpackage

// File: rtl/ccu_src_select.sv
// Source selector: captures the configured code during reset, keeps the
// active source and steers the matching oscillator tick to the divider.
// Assumes switch_now comes from the divider terminal count, so the source
// only changes between whole CPU clock periods.
module ccu_src_select
    import clkgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   cfg_code,
    input  logic               rc_force,
    input  logic               switch_now,
    input  logic [NUM_SRC-1:0] osc_tick,
    output osc_src_e           act_src,
    output logic               sel_tick
);
    osc_src_e cfg_q;
    osc_src_e want_src;

    // Purpose: latch configuration code while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= osc_src_e'(cfg_code);
    end

    // Purpose: pick the requested source, RC override first.
    always_comb begin
        want_src = rc_force ? SRC_RC : cfg_q;
    end

    // Purpose: hand over to the requested source at terminal count only.
    always_ff @(posedge clk) begin
        if (!rst_n)          act_src <= osc_src_e'(cfg_code);
        else if (switch_now) act_src <= want_src;
    end

    // Purpose: route the active oscillator tick.
    always_comb begin
        sel_tick = osc_tick[act_src];
    end
endmodule

// File: rtl/ccu_divider.sv
// Programmable divider: divide value 0 passes ticks straight through,
// value M gives one CPU enable per 2*M ticks. A new value is adopted
// at terminal count. Assumes tick is a one-cycle pulse.
module ccu_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_req,
    output logic             term,
    output logic             cpu_en
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] div_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Purpose: last count of a divided period (2*M - 1).
    always_comb begin
        limit = {div_act, 1'b0} - CNT_W'(1);
        term  = tick && ((div_act == '0) || (cnt == limit));
    end

    // Purpose: count ticks, emit enable and reload at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_act <= '0;
            cpu_en  <= 1'b0;
        end else begin
            cpu_en <= term;
            if (term) begin
                cnt     <= '0;
                div_act <= div_req;
            end else if (tick) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ccu_phase_out.sv
// Phase outputs: splits CPU enables into alternating peripheral and
// machine-cycle strobes and drives the half-rate clock output.
// Assumes allow already folds in enable and crystal-free conditions.
module ccu_phase_out (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_en,
    input  logic allow,
    output logic pclk_en,
    output logic mcyc_stb,
    output logic clkout
);
    logic ph;

    // Purpose: track CPU clock parity and emit half-rate strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= 1'b0;
            pclk_en  <= 1'b0;
            mcyc_stb <= 1'b0;
        end else begin
            ph       <= ph ^ cpu_en;
            pclk_en  <= cpu_en && !ph;
            mcyc_stb <= cpu_en && ph;
        end
    end

    // Purpose: toggle the clock output per CPU clock, or hold it low.
    always_ff @(posedge clk) begin
        if (!rst_n)     clkout <= 1'b0;
        else if (allow) clkout <= clkout ^ cpu_en;
        else            clkout <= 1'b0;
    end
endmodule

// File: rtl/clk_ctrl_unit.sv
// Clock control unit top: holds the control bits, selects the oscillator,
// divides it into CPU enables and derives the half-rate outputs.
// Assumes all oscillators arrive as ticks synchronous to clk.
module clk_ctrl_unit
    import clkgen_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] osc_tick,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic               ctl_we,
    input  logic               ctl_rc_force,
    input  logic               ctl_clkout_en,
    input  logic [DIV_W-1:0]   ctl_div,
    input  logic               rtc_on_xtal,
    input  logic               wdt_on_xtal,
    output logic               cpu_en,
    output logic               pclk_en,
    output logic               mcyc_stb,
    output logic               clkout
);
    logic             rc_q;
    logic             ce_q;
    logic [DIV_W-1:0] div_q;
    osc_src_e         act_src;
    logic             sel_tick;
    logic             div_term;
    logic             allow;

    // Purpose: control register bits written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q  <= 1'b0;
            ce_q  <= 1'b0;
            div_q <= '0;
        end else if (ctl_we) begin
            rc_q  <= ctl_rc_force;
            ce_q  <= ctl_clkout_en;
            div_q <= ctl_div;
        end
    end

    // Purpose: clock output permitted only while the crystal is free.
    always_comb begin
        allow = ce_q && (act_src != SRC_XTAL) && !rtc_on_xtal && !wdt_on_xtal;
    end

    ccu_src_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_code  (cfg_src),
        .rc_force  (rc_q),
        .switch_now(div_term),
        .osc_tick  (osc_tick),
        .act_src   (act_src),
        .sel_tick  (sel_tick)
    );

    ccu_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sel_tick),
        .div_req(div_q),
        .term   (div_term),
        .cpu_en (cpu_en)
    );

    ccu_phase_out u_ph (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_en  (cpu_en),
        .allow   (allow),
        .pclk_en (pclk_en),
        .mcyc_stb(mcyc_stb),
        .clkout  (clkout)
    );
endmodule

// File: rtl/clk_ctrl_unit_chk.sv
// Checker for the clock control unit, attached by bind.
// Assumes synchronous active-low reset; all properties disabled in reset.
module clk_ctrl_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] osc_tick,
    input logic       cpu_en,
    input logic       pclk_en,
    input logic       mcyc_stb,
    input logic       clkout,
    input logic       rtc_on_xtal,
    input logic       wdt_on_xtal,
    input logic [1:0] act_src,
    input logic       div_term
);
    assert_cpu_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> $past(|osc_tick));

    assert_src_change_at_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_src != $past(act_src)) |-> $past(div_term));

    assert_phases_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pclk_en && mcyc_stb));

    assert_pclk_after_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en || mcyc_stb) |-> $past(cpu_en));

    assert_clkout_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkout) |-> $past(cpu_en));

    assert_clkout_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_on_xtal || wdt_on_xtal || act_src == 2'd2) |=> !clkout);
endmodule

bind clk_ctrl_unit clk_ctrl_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .cpu_en     (cpu_en),
    .pclk_en    (pclk_en),
    .mcyc_stb   (mcyc_stb),
    .clkout     (clkout),
    .rtc_on_xtal(rtc_on_xtal),
    .wdt_on_xtal(wdt_on_xtal),
    .act_src    (act_src),
    .div_term   (div_term)
);

// File: tb/clk_ctrl_unit_test.sv
module clk_ctrl_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] osc_tick = '0;
    logic [1:0] cfg_src = '0;
    logic       ctl_we = 1'b0;
    logic       ctl_rc_force = 1'b0;
    logic       ctl_clkout_en = 1'b0;
    logic [7:0] ctl_div = '0;
    logic       rtc_on_xtal = 1'b0;
    logic       wdt_on_xtal = 1'b0;
    logic       cpu_en, pclk_en, mcyc_stb, clkout;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk_ctrl_unit uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_src(cfg_src),
        .ctl_we(ctl_we), .ctl_rc_force(ctl_rc_force), .ctl_clkout_en(ctl_clkout_en),
        .ctl_div(ctl_div), .rtc_on_xtal(rtc_on_xtal), .wdt_on_xtal(wdt_on_xtal),
        .cpu_en(cpu_en), .pclk_en(pclk_en), .mcyc_stb(mcyc_stb), .clkout(clkout)
    );

    function automatic logic [3:0] mask_of(input int code);
        return 4'(1 << code);
    endfunction

    function automatic int want_cpu(input int n, input int m);
        // n-th tick (1-based) after a terminal count with divide value m
        if (m == 0) return 1;
        return ((n % (2 * m)) == 0) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] code);
        rst_n = 1'b0; cfg_src = code; osc_tick = '0; ctl_we = 1'b0;
        rtc_on_xtal = 1'b0; wdt_on_xtal = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic write_ctl(input logic rc, input logic ce, input logic [7:0] m);
        ctl_we = 1'b1; ctl_rc_force = rc; ctl_clkout_en = ce; ctl_div = m;
        @(posedge clk);
        #1 ctl_we = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] t, output int c, output int p, output int y);
        osc_tick = t;
        @(posedge clk);
        #1 c = int'(cpu_en);
        osc_tick = '0;
        @(posedge clk);
        #1 p = int'(pclk_en);
        y = int'(mcyc_stb);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int c, p, y, cnt, last;
        void'($urandom(32'd4242));

        // R1: reset state
        do_reset(2'd2);
        chk("R1 cpu_en", int'(cpu_en), 0);
        chk("R1 pclk_en", int'(pclk_en), 0);
        chk("R1 mcyc_stb", int'(mcyc_stb), 0);
        chk("R1 clkout", int'(clkout), 0);

        // R2 / R3: each configured code selects its own tick only
        for (int code = 0; code < 4; code++) begin
            do_reset(2'(code));
            cfg_src = 2'($urandom % 4);
            for (int k = 0; k < 4; k++) begin
                int s = (code + 1 + k) % 4;
                pulse(mask_of(s), c, p, y);
                chk("R2 source select", c, (s == code) ? 1 : 0);
            end
            cfg_src = 2'(code ^ 1);
            pulse(mask_of(code ^ 1), c, p, y);
            chk("R3 cfg change ignored (other)", c, 0);
            pulse(mask_of(code), c, p, y);
            chk("R3 cfg change ignored (own)", c, 1);
        end

        // R4 / R7: RC override without reset
        do_reset(2'd0);
        write_ctl(1'b1, 1'b0, 8'd0);
        pulse(mask_of(1), c, p, y);
        chk("R7 rc before terminal", c, 0);
        pulse(mask_of(0), c, p, y);
        chk("R7 old source terminal", c, 1);
        pulse(mask_of(0), c, p, y);
        chk("R4 wdog ignored under force", c, 0);
        pulse(mask_of(1), c, p, y);
        chk("R4 rc active under force", c, 1);
        write_ctl(1'b0, 1'b0, 8'd0);
        pulse(mask_of(1), c, p, y);
        chk("R4 rc terminal on release", c, 1);
        pulse(mask_of(1), c, p, y);
        chk("R4 rc ignored after release", c, 0);
        pulse(mask_of(0), c, p, y);
        chk("R4 configured source restored", c, 1);

        // R5: pass-through with all ticks
        do_reset(2'd3);
        for (int i = 0; i < 4; i++) begin
            pulse(mask_of(3) | 4'($urandom % 8), c, p, y);
            chk("R5 pass-through", c, 1);
        end

        // R6: random divide values
        for (int it = 0; it < 6; it++) begin
            int m = 1 + int'($urandom % 6);
            do_reset(2'd3);
            write_ctl(1'b0, 1'b0, 8'(m));
            pulse(mask_of(3), c, p, y);
            chk("R6 load at terminal", c, 1);
            for (int n = 1; n <= 4 * m; n++) begin
                pulse(mask_of(3), c, p, y);
                chk("R6 divide by 2M", c, want_cpu(n, m));
            end
        end

        // R6: largest divide value
        do_reset(2'd1);
        write_ctl(1'b0, 1'b0, 8'd255);
        pulse(mask_of(1), c, p, y);
        cnt = 0; last = 0;
        for (int n = 1; n <= 510; n++) begin
            pulse(mask_of(1), c, p, y);
            cnt += c;
            last = c;
        end
        chk("R6 M=255 pulse count", cnt, 1);
        chk("R6 M=255 on 510th tick", last, 1);

        // R7: divide change mid-period waits for terminal count
        do_reset(2'd3);
        write_ctl(1'b0, 1'b0, 8'd3);
        pulse(mask_of(3), c, p, y);
        chk("R7 first load", c, 1);
        pulse(mask_of(3), c, p, y);
        pulse(mask_of(3), c, p, y);
        write_ctl(1'b0, 1'b0, 8'd1);
        for (int n = 3; n <= 6; n++) begin
            pulse(mask_of(3), c, p, y);
            chk("R7 old M kept until terminal", c, (n == 6) ? 1 : 0);
        end
        pulse(mask_of(3), c, p, y);
        chk("R7 new M tick 1", c, 0);
        pulse(mask_of(3), c, p, y);
        chk("R7 new M tick 2", c, 1);

        // R8: alternating half-rate strobes
        do_reset(2'd1);
        for (int i = 0; i < 6; i++) begin
            pulse(mask_of(1), c, p, y);
            chk("R8 pclk_en phase", p, (i % 2 == 0) ? 1 : 0);
            chk("R8 mcyc_stb phase", y, (i % 2 == 1) ? 1 : 0);
        end

        // R9: clock output toggles
        do_reset(2'd1);
        write_ctl(1'b0, 1'b1, 8'd0);
        for (int i = 0; i < 5; i++) begin
            pulse(mask_of(1), c, p, y);
            chk("R9 clkout level", int'(clkout), (i + 1) % 2);
        end

        // R10: blocking conditions
        rtc_on_xtal = 1'b1;
        pulse(mask_of(1), c, p, y);
        chk("R10 rtc on crystal", int'(clkout), 0);
        rtc_on_xtal = 1'b0;
        pulse(mask_of(1), c, p, y);
        chk("R9 clkout resumes", int'(clkout), 1);
        wdt_on_xtal = 1'b1;
        pulse(mask_of(1), c, p, y);
        chk("R10 wdt on crystal", int'(clkout), 0);
        wdt_on_xtal = 1'b0;
        pulse(mask_of(1), c, p, y);
        write_ctl(1'b0, 1'b0, 8'd0);
        @(posedge clk); #1;
        chk("R10 output disabled", int'(clkout), 0);
        do_reset(2'd2);
        write_ctl(1'b0, 1'b1, 8'd0);
        for (int i = 0; i < 3; i++) begin
            pulse(mask_of(2), c, p, y);
            chk("R10 crystal is cpu source", int'(clkout), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule